// File: doc/BRIEF.md
# Interrupt Controller Base and Identity Register Unit

This unit holds the per-processor state that places a local interrupt controller in the system. It covers the base register with its address, enable, extended-addressing and boot-processor fields, the local identity, and the values the controller's other registers take whenever the processor receives an INIT. A bus-facing wrapper drives the base, identity and boot-designation write strobes. Neighbouring logic reads the registered outputs: the effective identity, the task priority, the spurious vector, the destination fields, the in-service, trigger and request vectors, the error and command words, the local vector table entries and the wait-for-startup flag.

There are three reset levels. Power-on `rst` loads everything, including the boot-processor field, from parameters. A full reset rebuilds the base register but keeps the boot-processor field it already holds, and it restores the identity. An INIT reset reloads only the controller defaults. The identity depends on the addressing mode. In legacy mode it is an 8-bit register that software can write. In extended mode it reads as the 32-bit initial identity fixed by the `INIT_ID` parameter, and that value is copied back into the 8-bit register when the block enters extended mode.

Top module: `lic_idbase`

## Requirements
- R1: After power-on reset, base_o is 0xFEE00000 OR the enable bit (bit 11) OR `BOOT_POR` in bit 8. id_o is `INIT_ID[7:0]` zero-extended. wait_sipi_o is the inverse of `BOOT_POR`.
- R2: A base write that sets bit 10 (extended mode) while bit 10 is currently clear reloads the 8-bit local identity with `INIT_ID[7:0]`.
- R3: A base write loads all 32 bits of its data into base_o one cycle later.
- R4: A full reset makes base_o equal 0xFEE00000 OR bit 11 OR the boot bit (bit 8) held before the reset. Every other bit is zero.
- R5: A full reset restores the local identity to `INIT_ID[7:0]` and also performs every action of an INIT reset.
- R6: INIT reset sets the task priority to 0x00, the spurious vector to 0xFF, the logical destination to 0x00 and the destination format to 0xF.
- R7: INIT reset clears the in-service, trigger and request vectors (`NVEC` bits each), the error word and both command words. It sets each local vector table entry to only its mask bit, bit 16.
- R8: INIT reset and full reset set wait_sipi_o to 1 when the boot bit is clear and to 0 when it is set. Power-on reset follows R1.
- R9: When base bit 10 is set, id_o is the full 32-bit `INIT_ID`. Otherwise id_o is the 8-bit local identity zero-extended.
- R10: A boot-designation write changes only base bit 8, to boot_val_i. All other base bits are unchanged.
- R11: An identity write loads the local identity only when bit 10 is clear both before and after that cycle. Otherwise it is ignored.
- R12: Full reset overrides base, identity and boot writes in the same cycle. A boot-designation write overrides bit 8 of a base write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| full_rst_i | input | 1 | Full controller reset |
| init_i | input | 1 | INIT reset |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | Base register write data |
| boot_we_i | input | 1 | Boot-processor designation strobe |
| boot_val_i | input | 1 | Boot-processor designation value |
| id_we_i | input | 1 | Local identity write strobe |
| id_wdata_i | input | 8 | Local identity write data |
| base_o | output | 32 | Current base register |
| id_o | output | 32 | Effective identity |
| tpr_o | output | 8 | Task priority |
| spur_o | output | 8 | Spurious vector |
| ldest_o | output | 8 | Logical destination |
| dfmt_o | output | 4 | Destination format |
| esr_o | output | 32 | Error status word |
| cmd_lo_o | output | 32 | Command word, low |
| cmd_hi_o | output | 32 | Command word, high |
| isr_o | output | NVEC | In-service vector |
| tmr_o | output | NVEC | Trigger-mode vector |
| irr_o | output | NVEC | Request vector |
| lvt_o | output | NLVT*32 | Local vector table entries, packed, entry 0 in the low bits |
| wait_sipi_o | output | 1 | Waiting for startup message |

## Verification
Every output is a register, so the effect of any strobe or reset is visible exactly one clock after the edge that samples it. There are no further stages. The driver applies each stimulus on a falling edge and pushes the values the requirements predict. The monitor pops them 2 ns after the following rising edge, which is the first point where the new register values are stable. The INIT defaults are compared at the same point after an INIT or full reset, and the wait flag is compared to the boot bit that was held before that reset.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BASE_W       = 32;
  localparam int LID_W        = 8;
  localparam int BOOT_BIT     = 8;
  localparam int EXT_BIT      = 10;
  localparam int EN_BIT       = 11;
  localparam int LVT_W        = 32;
  localparam int LVT_MASK_BIT = 16;
  localparam logic [19:0] DEF_ADDR = 20'hFEE00;

  function automatic logic [BASE_W-1:0] rebuilt_base(input logic boot);
    logic [BASE_W-1:0] b;
    b = '0;
    b[BASE_W-1:12] = DEF_ADDR;
    b[EN_BIT]      = 1'b1;
    b[BOOT_BIT]    = boot;
    return b;
  endfunction
endpackage

// File: rtl/lic_base_id.sv
module lic_base_id
  import lic_pkg::*;
#(
  parameter logic [31:0] INIT_ID  = 32'h0000_0123,
  parameter logic        BOOT_POR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_rst_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              boot_we_i,
  input  logic              boot_val_i,
  input  logic              id_we_i,
  input  logic [LID_W-1:0]  id_wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [31:0]       id_o,
  output logic              boot_o
);
  logic [BASE_W-1:0] base_q, base_n;
  logic [LID_W-1:0]  lid_q, lid_n;
  logic [31:0]       id_q, id_n;
  logic              entering_ext;

  assign entering_ext = base_we_i && base_wdata_i[EXT_BIT] && !base_q[EXT_BIT];

  always_comb begin
    base_n = base_q;
    lid_n  = lid_q;
    if (full_rst_i) begin
      base_n = rebuilt_base(base_q[BOOT_BIT]);
      lid_n  = INIT_ID[LID_W-1:0];
    end else begin
      if (base_we_i) base_n = base_wdata_i;
      if (boot_we_i) base_n[BOOT_BIT] = boot_val_i;
      if (entering_ext) lid_n = INIT_ID[LID_W-1:0];
      else if (id_we_i && !base_q[EXT_BIT] && !base_n[EXT_BIT]) lid_n = id_wdata_i;
    end
    id_n = base_n[EXT_BIT] ? INIT_ID : {{(32-LID_W){1'b0}}, lid_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= rebuilt_base(BOOT_POR);
      lid_q  <= INIT_ID[LID_W-1:0];
      id_q   <= {{(32-LID_W){1'b0}}, INIT_ID[LID_W-1:0]};
    end else begin
      base_q <= base_n;
      lid_q  <= lid_n;
      id_q   <= id_n;
    end
  end

  assign base_o = base_q;
  assign id_o   = id_q;
  assign boot_o = base_q[BOOT_BIT];

  // R2
  ext_entry_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_rst_i && base_we_i && base_wdata_i[EXT_BIT] && !base_q[EXT_BIT])
      |=> (lid_q == INIT_ID[LID_W-1:0]));

  // R4
  full_rebuild_chk: assert property (@(posedge clk) disable iff (rst)
    full_rst_i |=> (base_q == rebuilt_base($past(base_q[BOOT_BIT]))));

  // R10
  boot_only_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (boot_we_i && !base_we_i && !full_rst_i)
      |=> (base_q[BOOT_BIT] == $past(boot_val_i)) &&
          ((base_q ^ $past(base_q)) & ~(32'h1 << BOOT_BIT)) == '0);
endmodule

// File: rtl/lic_init_regs.sv
module lic_init_regs
  import lic_pkg::*;
#(
  parameter int   NVEC     = 256,
  parameter int   NLVT     = 6,
  parameter logic BOOT_POR = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  full_rst_i,
  input  logic                  init_i,
  input  logic                  boot_i,
  output logic [7:0]            tpr_o,
  output logic [7:0]            spur_o,
  output logic [7:0]            ldest_o,
  output logic [3:0]            dfmt_o,
  output logic [31:0]           esr_o,
  output logic [31:0]           cmd_lo_o,
  output logic [31:0]           cmd_hi_o,
  output logic [NVEC-1:0]       isr_o,
  output logic [NVEC-1:0]       tmr_o,
  output logic [NVEC-1:0]       irr_o,
  output logic [NLVT*LVT_W-1:0] lvt_o,
  output logic                  wait_o
);
  localparam logic [LVT_W-1:0] LVT_DEF = LVT_W'(1) << LVT_MASK_BIT;

  logic do_init;
  assign do_init = rst || full_rst_i || init_i;

  always_ff @(posedge clk) begin
    if (do_init) begin
      tpr_o    <= 8'h00;
      spur_o   <= 8'hFF;
      ldest_o  <= 8'h00;
      dfmt_o   <= 4'hF;
      esr_o    <= '0;
      cmd_lo_o <= '0;
      cmd_hi_o <= '0;
      isr_o    <= '0;
      tmr_o    <= '0;
      irr_o    <= '0;
    end
  end

  for (genvar e = 0; e < NLVT; e++) begin : g_lvt
    logic [LVT_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (do_init) ent_q <= LVT_DEF;
    end
    assign lvt_o[e*LVT_W +: LVT_W] = ent_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                       wait_o <= !BOOT_POR;
    else if (full_rst_i || init_i) wait_o <= !boot_i;
  end

  // R6
  init_scalar_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (tpr_o == 8'h00 && spur_o == 8'hFF && ldest_o == 8'h00 && dfmt_o == 4'hF));

  // R8
  wait_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (init_i || full_rst_i) |=> (wait_o == !$past(boot_i)));

  // R7
  vec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (isr_o == '0 && tmr_o == '0 && irr_o == '0));
endmodule

// File: rtl/lic_idbase.sv
module lic_idbase
  import lic_pkg::*;
#(
  parameter logic [31:0] INIT_ID  = 32'h0000_0123,
  parameter logic        BOOT_POR = 1'b1,
  parameter int          NVEC     = 256,
  parameter int          NLVT     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  full_rst_i,
  input  logic                  init_i,
  input  logic                  base_we_i,
  input  logic [31:0]           base_wdata_i,
  input  logic                  boot_we_i,
  input  logic                  boot_val_i,
  input  logic                  id_we_i,
  input  logic [7:0]            id_wdata_i,
  output logic [31:0]           base_o,
  output logic [31:0]           id_o,
  output logic [7:0]            tpr_o,
  output logic [7:0]            spur_o,
  output logic [7:0]            ldest_o,
  output logic [3:0]            dfmt_o,
  output logic [31:0]           esr_o,
  output logic [31:0]           cmd_lo_o,
  output logic [31:0]           cmd_hi_o,
  output logic [NVEC-1:0]       isr_o,
  output logic [NVEC-1:0]       tmr_o,
  output logic [NVEC-1:0]       irr_o,
  output logic [NLVT*32-1:0]    lvt_o,
  output logic                  wait_sipi_o
);
  logic boot_bit;

  lic_base_id #(.INIT_ID(INIT_ID), .BOOT_POR(BOOT_POR)) u_base (
    .clk(clk), .rst(rst), .full_rst_i(full_rst_i),
    .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .boot_we_i(boot_we_i), .boot_val_i(boot_val_i),
    .id_we_i(id_we_i), .id_wdata_i(id_wdata_i),
    .base_o(base_o), .id_o(id_o), .boot_o(boot_bit)
  );

  lic_init_regs #(.NVEC(NVEC), .NLVT(NLVT), .BOOT_POR(BOOT_POR)) u_init (
    .clk(clk), .rst(rst), .full_rst_i(full_rst_i), .init_i(init_i),
    .boot_i(boot_bit),
    .tpr_o(tpr_o), .spur_o(spur_o), .ldest_o(ldest_o), .dfmt_o(dfmt_o),
    .esr_o(esr_o), .cmd_lo_o(cmd_lo_o), .cmd_hi_o(cmd_hi_o),
    .isr_o(isr_o), .tmr_o(tmr_o), .irr_o(irr_o), .lvt_o(lvt_o),
    .wait_o(wait_sipi_o)
  );

  // R9
  ext_id_view_chk: assert property (@(posedge clk) disable iff (rst)
    base_o[EXT_BIT] |-> (id_o == INIT_ID));

  // R9
  legacy_id_view_chk: assert property (@(posedge clk) disable iff (rst)
    !base_o[EXT_BIT] |-> (id_o[31:8] == 24'h0));
endmodule

// File: tb/lic_idbase_test.sv
`timescale 1ns/1ps
module lic_idbase_test;
  localparam logic [31:0] INIT_ID = 32'h0000_0123;
  localparam int NVEC = 256;
  localparam int NLVT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic full_rst_i = 0, init_i = 0, base_we_i = 0, boot_we_i = 0, boot_val_i = 0, id_we_i = 0;
  logic [31:0] base_wdata_i = '0;
  logic [7:0]  id_wdata_i = '0;
  logic [31:0] base_o, id_o, esr_o, cmd_lo_o, cmd_hi_o;
  logic [7:0]  tpr_o, spur_o, ldest_o;
  logic [3:0]  dfmt_o;
  logic [NVEC-1:0] isr_o, tmr_o, irr_o;
  logic [NLVT*32-1:0] lvt_o;
  logic wait_sipi_o;

  always #4 clk = ~clk;

  lic_idbase #(.INIT_ID(INIT_ID), .BOOT_POR(1'b1), .NVEC(NVEC), .NLVT(NLVT)) uut (
    .clk(clk), .rst(rst), .full_rst_i(full_rst_i), .init_i(init_i),
    .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .boot_we_i(boot_we_i), .boot_val_i(boot_val_i),
    .id_we_i(id_we_i), .id_wdata_i(id_wdata_i),
    .base_o(base_o), .id_o(id_o), .tpr_o(tpr_o), .spur_o(spur_o),
    .ldest_o(ldest_o), .dfmt_o(dfmt_o), .esr_o(esr_o), .cmd_lo_o(cmd_lo_o),
    .cmd_hi_o(cmd_hi_o), .isr_o(isr_o), .tmr_o(tmr_o), .irr_o(irr_o),
    .lvt_o(lvt_o), .wait_sipi_o(wait_sipi_o)
  );

  typedef struct {
    logic [31:0] base;
    logic [31:0] id;
    logic        wt;
    logic        dflt;
    string       tag;
  } exp_t;

  exp_t exq[$];
  int runs = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_base;
  logic [7:0]  m_lid;
  logic        m_wait;

  task automatic chk32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_defaults(input string tag);
    logic ok;
    ok = (tpr_o == 8'h00) && (spur_o == 8'hFF) && (ldest_o == 8'h00) && (dfmt_o == 4'hF);
    chk32({tag, "/R6"}, "scalars", {31'd0, ok}, 32'd1);
    ok = (isr_o == '0) && (tmr_o == '0) && (irr_o == '0) && (esr_o == '0) &&
         (cmd_lo_o == '0) && (cmd_hi_o == '0);
    for (int e = 0; e < NLVT; e++) if (lvt_o[e*32 +: 32] !== 32'h0001_0000) ok = 0;
    chk32({tag, "/R7"}, "vectors+lvt", {31'd0, ok}, 32'd1);
  endtask

  function automatic logic [31:0] eff_id();
    return m_base[10] ? INIT_ID : {24'h0, m_lid};
  endfunction

  // driver: applies one cycle of stimulus and pushes the predicted result
  task automatic step(input logic fr, input logic in, input logic bw, input logic [31:0] bd,
                      input logic kw, input logic kv, input logic iw, input logic [7:0] idd,
                      input string tag);
    exp_t x;
    logic [31:0] nb;
    logic [7:0]  nl;
    @(negedge clk);
    full_rst_i = fr; init_i = in; base_we_i = bw; base_wdata_i = bd;
    boot_we_i = kw; boot_val_i = kv; id_we_i = iw; id_wdata_i = idd;
    nb = m_base; nl = m_lid;
    if (fr) begin
      nb = 32'hFEE0_0800 | {23'h0, m_base[8], 8'h0};
      nl = INIT_ID[7:0];
      m_wait = !m_base[8];
    end else begin
      if (bw) nb = bd;
      if (kw) nb[8] = kv;
      if (bw && bd[10] && !m_base[10]) nl = INIT_ID[7:0];
      else if (iw && !m_base[10] && !nb[10]) nl = idd;
      if (in) m_wait = !m_base[8];
    end
    m_base = nb; m_lid = nl;
    x.base = m_base; x.id = eff_id(); x.wt = m_wait; x.dflt = fr || in; x.tag = tag;
    exq.push_back(x);
    @(posedge clk);
    @(negedge clk);
    full_rst_i = 0; init_i = 0; base_we_i = 0; boot_we_i = 0; id_we_i = 0;
  endtask

  // monitor: compares outputs one register stage after the stimulus edge
  always @(posedge clk) begin
    #2;
    if (exq.size() > 0) begin
      exp_t x;
      x = exq.pop_front();
      chk32(x.tag, "base", base_o, x.base);
      chk32(x.tag, "id", id_o, x.id);
      chk32(x.tag, "wait", {31'd0, wait_sipi_o}, {31'd0, x.wt});
      if (x.dflt) chk_defaults(x.tag);
    end
  end

  initial begin
    #(8 * 4000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 power-on state
    chk32("R1", "base", base_o, 32'hFEE0_0900);
    chk32("R1", "id", id_o, 32'h0000_0023);
    chk32("R1", "wait", {31'd0, wait_sipi_o}, 32'd0);
    chk_defaults("R1");
    m_base = 32'hFEE0_0900; m_lid = 8'h23; m_wait = 0;

    step(0,0, 0,'0,          0,0, 1,8'h55, "R11 legacy id write");
    step(0,0, 1,32'hFEE0_0D00, 0,0, 0,8'h00, "R2 enter ext / R9");
    step(0,0, 0,'0,          0,0, 1,8'h77, "R11 id write ignored in ext");
    step(0,0, 1,32'h1234_5100, 0,0, 0,8'h00, "R3 full base load");
    step(0,0, 0,'0,          0,0, 1,8'h41, "R11 id write legacy again");
    step(0,0, 0,'0,          1,0, 0,8'h00, "R10 boot clear");
    step(0,1, 0,'0,          0,0, 0,8'h00, "R8 init non-boot");
    step(0,0, 1,32'h0000_0000, 1,1, 0,8'h00, "R12 boot over base write");
    step(0,1, 0,'0,          0,0, 0,8'h00, "R8 init boot");
    step(0,0, 0,'0,          0,0, 1,8'h66, "R11 id write");
    step(1,0, 1,32'hFFFF_FFFF, 1,0, 1,8'h99, "R12 R4 R5 full reset wins");
    step(0,0, 1,32'hFEE0_0400, 0,0, 0,8'h00, "R2 enter ext from reset");
    step(0,0, 1,32'hFEE0_0000, 0,0, 1,8'h12, "R11 leaving ext blocks id write");
    step(0,0, 0,'0,          1,0, 0,8'h00, "R10 boot clear");
    step(1,0, 0,'0,          0,0, 0,8'h00, "R4 R5 R8 full reset non-boot");
    step(0,0, 0,'0,          0,0, 0,8'h00, "R9 idle hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule